// File: doc/BRIEF.md
# Bit-Addressable Scratchpad Memory with Boolean Carry Unit

This block is a 128-byte internal data memory with two access paths. A byte path reads any location combinationally and writes it on the clock edge. A bit path reaches a fixed 16-byte window of that memory one bit at a time. The window runs from byte 0x20 to byte 0x2F, which gives 128 addressable bits.

The bit path also drives a one-bit carry register. A 4-bit operation code selects what happens to the addressed bit and to carry:

- clear, set or complement the bit;
- clear, set or complement carry;
- AND or OR carry with the bit or with its inverse;
- copy the bit into carry, or copy carry into the bit;
- test-and-clear.

A processor datapath uses the block as its register-bank, stack and Boolean scratch storage. Instruction decode sits outside the block and presents one bit operation and one byte access per cycle.

Every bit write is a read-modify-write of the byte that holds the bit, and it completes in a single cycle. When both paths write the same byte in one cycle, the byte path wins.

Top module: `scratch_bitmem`

## Requirements
- R1: The block holds 128 bytes at byte addresses 0x00 to 0x7F. A byte write (`byte_we_i`=1) stores `byte_wdata_i` at `byte_addr_i` on the rising edge. `byte_rdata_o` always shows the stored byte at `byte_addr_i`, combinationally.
- R2: Bit address b selects byte 0x20 + b[6:3] and bit position b[2:0] inside it. `bit_val_o` always shows the current value of that bit, combinationally.
- R3: With `bit_valid_i`=1, codes 0, 1 and 2 clear, set and complement the addressed bit at the clock edge. The other seven bits of that byte are left unchanged.
- R4: With `bit_valid_i`=1, codes 3, 4 and 5 clear, set and complement carry at the clock edge.
- R5: With `bit_valid_i`=1, the following codes update carry at the edge:
  - code 6: carry becomes carry AND bit;
  - code 7: carry becomes carry AND NOT bit;
  - code 8: carry becomes carry OR bit;
  - code 9: carry becomes carry OR NOT bit.
- R6: With `bit_valid_i`=1, code 10 copies the addressed bit into carry, and code 11 copies carry into the addressed bit.
- R7: Code 12 (test-and-clear) works as follows:
  - `bit_val_o` shows the bit's value before the edge;
  - the bit is cleared at the edge;
  - carry is unchanged.
- R8: When a byte write and a bit write target the same byte in one cycle, the byte write's data is stored. When they target different bytes, both take effect.
- R9: `carry_o` is 0 after reset. Carry changes only under codes 3 to 10 with `bit_valid_i`=1.
- R10: Codes 13 to 15 change neither memory nor carry.
- R11: With `bit_valid_i`=0, no bit operation changes memory or carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset (carry only) |
| byte_we_i | input | 1 | Byte write enable |
| byte_addr_i | input | 7 | Byte address |
| byte_wdata_i | input | 8 | Byte write data |
| byte_rdata_o | output | 8 | Byte read data at `byte_addr_i` |
| bit_valid_i | input | 1 | Bit operation valid |
| bit_addr_i | input | 7 | Bit address within the 16-byte window |
| bit_op_i | input | 4 | Bit operation code |
| bit_val_o | output | 1 | Current value of the addressed bit |
| carry_o | output | 1 | Carry flag |

## Verification
The assertions check on every cycle that carry holds its value unless a carry-writing code is valid. They also check the carry results of set, clear, AND, OR and move-to-carry, that a byte write reads back on the next cycle, and that a tested bit reads zero after test-and-clear.

Only the bench scenarios can show the following:
- the address mapping of the window;
- that the seven neighbouring bits survive a bit write;
- that the byte path wins on a same-byte collision while writes to distinct bytes both land;
- that reserved codes and invalid cycles leave memory intact.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [3:0] {
    OP_BIT_CLR  = 4'd0,
    OP_BIT_SET  = 4'd1,
    OP_BIT_CPL  = 4'd2,
    OP_CY_CLR   = 4'd3,
    OP_CY_SET   = 4'd4,
    OP_CY_CPL   = 4'd5,
    OP_CY_AND   = 4'd6,
    OP_CY_ANDN  = 4'd7,
    OP_CY_OR    = 4'd8,
    OP_CY_ORN   = 4'd9,
    OP_CY_LOAD  = 4'd10,
    OP_BIT_STOR = 4'd11,
    OP_TST_CLR  = 4'd12
  } bit_op_e;

  typedef struct packed {
    logic bit_we;
    logic bit_new;
    logic cy_we;
    logic cy_new;
  } bool_res_t;
endpackage

// File: rtl/sbm_bit_map.sv
module sbm_bit_map #(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  parameter int BIT_AW   = 7,
  parameter int WIN_BASE = 32,
  localparam int POS_W   = $clog2(DATA_W),
  localparam int ROW_W   = BIT_AW - POS_W
) (
  input  logic [BIT_AW-1:0] bit_addr_i,
  output logic [ADDR_W-1:0] byte_idx_o,
  output logic [POS_W-1:0]  bit_pos_o
);
  logic [ROW_W-1:0] row;

  assign row        = bit_addr_i[BIT_AW-1:POS_W];
  assign bit_pos_o  = bit_addr_i[POS_W-1:0];
  assign byte_idx_o = ADDR_W'(WIN_BASE) + ADDR_W'(row);
endmodule

// File: rtl/sbm_bool_unit.sv
module sbm_bool_unit
  import sbm_pkg::*;
(
  input  logic      valid_i,
  input  logic [3:0] op_i,
  input  logic      cur_bit_i,
  input  logic      carry_i,
  output bool_res_t res_o
);
  always_comb begin
    res_o = '0;
    if (valid_i) begin
      unique case (op_i)
        OP_BIT_CLR:  begin res_o.bit_we = 1'b1; res_o.bit_new = 1'b0;       end
        OP_BIT_SET:  begin res_o.bit_we = 1'b1; res_o.bit_new = 1'b1;       end
        OP_BIT_CPL:  begin res_o.bit_we = 1'b1; res_o.bit_new = ~cur_bit_i; end
        OP_CY_CLR:   begin res_o.cy_we = 1'b1;  res_o.cy_new = 1'b0;        end
        OP_CY_SET:   begin res_o.cy_we = 1'b1;  res_o.cy_new = 1'b1;        end
        OP_CY_CPL:   begin res_o.cy_we = 1'b1;  res_o.cy_new = ~carry_i;    end
        OP_CY_AND:   begin res_o.cy_we = 1'b1;  res_o.cy_new = carry_i & cur_bit_i;  end
        OP_CY_ANDN:  begin res_o.cy_we = 1'b1;  res_o.cy_new = carry_i & ~cur_bit_i; end
        OP_CY_OR:    begin res_o.cy_we = 1'b1;  res_o.cy_new = carry_i | cur_bit_i;  end
        OP_CY_ORN:   begin res_o.cy_we = 1'b1;  res_o.cy_new = carry_i | ~cur_bit_i; end
        OP_CY_LOAD:  begin res_o.cy_we = 1'b1;  res_o.cy_new = cur_bit_i;   end
        OP_BIT_STOR: begin res_o.bit_we = 1'b1; res_o.bit_new = carry_i;    end
        OP_TST_CLR:  begin res_o.bit_we = 1'b1; res_o.bit_new = 1'b0;       end
        default:     res_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/sbm_store.sv
module sbm_store #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int POS_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              byte_we_i,
  input  logic [ADDR_W-1:0] byte_addr_i,
  input  logic [DATA_W-1:0] byte_wdata_i,
  output logic [DATA_W-1:0] byte_rdata_o,
  input  logic              bit_we_i,
  input  logic [ADDR_W-1:0] bit_byte_i,
  input  logic [POS_W-1:0]  bit_pos_i,
  input  logic              bit_new_i,
  output logic [DATA_W-1:0] bit_row_o
);
  logic [DEPTH-1:0][DATA_W-1:0] rows;

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    logic [DATA_W-1:0] row_q;
    logic              hit_byte, hit_bit;

    assign hit_byte = byte_we_i && (byte_addr_i == ADDR_W'(g));
    assign hit_bit  = bit_we_i  && (bit_byte_i  == ADDR_W'(g));

    // byte path wins on collision; contents are not reset
    always_ff @(posedge clk_i) begin
      if (hit_byte)     row_q <= byte_wdata_i;
      else if (hit_bit) row_q[bit_pos_i] <= bit_new_i;
    end
    assign rows[g] = row_q;
  end

  assign byte_rdata_o = rows[byte_addr_i];
  assign bit_row_o    = rows[bit_byte_i];
endmodule

// File: rtl/scratch_bitmem.sv
module scratch_bitmem
  import sbm_pkg::*;
#(
  parameter int DEPTH    = 128,
  parameter int DATA_W   = 8,
  parameter int BIT_AW   = 7,
  parameter int WIN_BASE = 32,
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int POS_W   = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_we_i,
  input  logic [ADDR_W-1:0] byte_addr_i,
  input  logic [DATA_W-1:0] byte_wdata_i,
  output logic [DATA_W-1:0] byte_rdata_o,
  input  logic              bit_valid_i,
  input  logic [BIT_AW-1:0] bit_addr_i,
  input  logic [3:0]        bit_op_i,
  output logic              bit_val_o,
  output logic              carry_o
);
  logic [ADDR_W-1:0] bit_byte;
  logic [POS_W-1:0]  bit_pos;
  logic [DATA_W-1:0] bit_row;
  logic              carry_q;
  bool_res_t         res;

  sbm_bit_map #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_AW(BIT_AW), .WIN_BASE(WIN_BASE)
  ) u_map (
    .bit_addr_i(bit_addr_i),
    .byte_idx_o(bit_byte),
    .bit_pos_o (bit_pos)
  );

  assign bit_val_o = bit_row[bit_pos];

  sbm_bool_unit u_bool (
    .valid_i  (bit_valid_i),
    .op_i     (bit_op_i),
    .cur_bit_i(bit_val_o),
    .carry_i  (carry_q),
    .res_o    (res)
  );

  sbm_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk_i       (clk_i),
    .byte_we_i   (byte_we_i),
    .byte_addr_i (byte_addr_i),
    .byte_wdata_i(byte_wdata_i),
    .byte_rdata_o(byte_rdata_o),
    .bit_we_i    (res.bit_we),
    .bit_byte_i  (bit_byte),
    .bit_pos_i   (bit_pos),
    .bit_new_i   (res.bit_new),
    .bit_row_o   (bit_row)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       carry_q <= 1'b0;
    else if (res.cy_we) carry_q <= res.cy_new;
  end

  assign carry_o = carry_q;
endmodule

// File: rtl/sbm_checker.sv
module sbm_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       byte_we_i,
  input logic [6:0] byte_addr_i,
  input logic [7:0] byte_wdata_i,
  input logic [7:0] byte_rdata_o,
  input logic       bit_valid_i,
  input logic [6:0] bit_addr_i,
  input logic [3:0] bit_op_i,
  input logic       bit_val_o,
  input logic       carry_o
);
  logic cy_op;
  assign cy_op = bit_valid_i && (bit_op_i >= 4'd3) && (bit_op_i <= 4'd10);

  a_r9_carry_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cy_op |=> $stable(carry_o));

  a_r4_carry_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_i && bit_op_i == 4'd4) |=> carry_o);

  a_r4_carry_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_i && bit_op_i == 4'd3) |=> !carry_o);

  a_r5_carry_and: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_i && bit_op_i == 4'd6) |=> carry_o == ($past(carry_o) & $past(bit_val_o)));

  a_r5_carry_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_i && bit_op_i == 4'd8) |=> carry_o == ($past(carry_o) | $past(bit_val_o)));

  a_r6_carry_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_i && bit_op_i == 4'd10) |=> carry_o == $past(bit_val_o));

  a_r1_byte_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_we_i |=> ((byte_addr_i == $past(byte_addr_i)) -> (byte_rdata_o == $past(byte_wdata_i))));

  a_r7_test_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_i && bit_op_i == 4'd12 && !byte_we_i)
      |=> ((bit_addr_i == $past(bit_addr_i)) -> !bit_val_o));
endmodule

bind scratch_bitmem sbm_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .byte_we_i(byte_we_i), .byte_addr_i(byte_addr_i), .byte_wdata_i(byte_wdata_i),
  .byte_rdata_o(byte_rdata_o),
  .bit_valid_i(bit_valid_i), .bit_addr_i(bit_addr_i), .bit_op_i(bit_op_i),
  .bit_val_o(bit_val_o), .carry_o(carry_o)
);

// File: tb/scratch_bitmem_tb.sv
module scratch_bitmem_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_we = 1'b0;
  logic [6:0] byte_addr = '0;
  logic [7:0] byte_wdata = '0;
  logic [7:0] byte_rdata;
  logic       bit_valid = 1'b0;
  logic [6:0] bit_addr = '0;
  logic [3:0] bit_op = '0;
  logic       bit_val, carry;

  int checks = 0;
  int errors = 0;
  logic [7:0] ref_mem [128];
  logic       ref_cy;

  always #5 clk = ~clk;

  scratch_bitmem dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .byte_we_i(byte_we), .byte_addr_i(byte_addr), .byte_wdata_i(byte_wdata),
    .byte_rdata_o(byte_rdata),
    .bit_valid_i(bit_valid), .bit_addr_i(bit_addr), .bit_op_i(bit_op),
    .bit_val_o(bit_val), .carry_o(carry)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    byte_we = 1'b0;
    bit_valid = 1'b0;
  endtask

  task automatic wr_byte(logic [6:0] a, logic [7:0] d);
    byte_we = 1'b1; byte_addr = a; byte_wdata = d;
    step();
    ref_mem[a] = d;
  endtask

  // requirement-level model of one bit operation
  task automatic bit_cmd(logic [3:0] op, logic [6:0] b);
    logic [6:0] ba;
    logic [2:0] p;
    logic       cur;
    ba = 7'h20 + {3'b0, b[6:3]};
    p = b[2:0];
    cur = ref_mem[ba][p];
    bit_valid = 1'b1; bit_op = op; bit_addr = b;
    step();
    case (op)
      4'd0, 4'd12: ref_mem[ba][p] = 1'b0;
      4'd1:  ref_mem[ba][p] = 1'b1;
      4'd2:  ref_mem[ba][p] = ~cur;
      4'd3:  ref_cy = 1'b0;
      4'd4:  ref_cy = 1'b1;
      4'd5:  ref_cy = ~ref_cy;
      4'd6:  ref_cy = ref_cy & cur;
      4'd7:  ref_cy = ref_cy & ~cur;
      4'd8:  ref_cy = ref_cy | cur;
      4'd9:  ref_cy = ref_cy | ~cur;
      4'd10: ref_cy = cur;
      4'd11: ref_mem[ba][p] = ref_cy;
      default: ;
    endcase
  endtask

  task automatic chk_byte(string tag, logic [6:0] a);
    byte_addr = a;
    #1;
    check(tag, byte_rdata, ref_mem[a]);
  endtask

  task automatic t_reset();
    check("R9 reset carry", {7'b0, carry}, 8'h00);
  endtask

  task automatic t_bytes();
    for (int i = 32; i < 48; i++) wr_byte(7'(i), 8'h00);
    wr_byte(7'h05, 8'hA5);
    wr_byte(7'h7F, 8'h3C);
    wr_byte(7'h30, 8'h11);
    chk_byte("R1 byte 05", 7'h05);
    chk_byte("R1 byte 7F", 7'h7F);
    chk_byte("R1 byte 30", 7'h30);
  endtask

  task automatic t_map();
    wr_byte(7'h23, 8'h40);
    bit_addr = 7'h1E; #1;
    check("R2 bit 1E", {7'b0, bit_val}, 8'h01);
    bit_addr = 7'h1D; #1;
    check("R2 bit 1D", {7'b0, bit_val}, 8'h00);
  endtask

  task automatic t_bitops();
    wr_byte(7'h21, 8'hA5);
    bit_cmd(4'd1, 7'h00); chk_byte("R3 set bit0 of 20", 7'h20);
    bit_cmd(4'd1, 7'h7F); chk_byte("R3 set bit7 of 2F", 7'h2F);
    bit_cmd(4'd2, 7'h1E); chk_byte("R3 cpl 23", 7'h23);
    bit_cmd(4'd0, 7'h08); chk_byte("R3 clr bit0 of 21", 7'h21);
    bit_cmd(4'd2, 7'h0E); chk_byte("R3 cpl bit6 of 21", 7'h21);
  endtask

  task automatic t_carry();
    bit_cmd(4'd4, 7'h00); check("R4 set carry", {7'b0, carry}, {7'b0, ref_cy});
    bit_cmd(4'd5, 7'h00); check("R4 cpl carry", {7'b0, carry}, {7'b0, ref_cy});
    bit_cmd(4'd5, 7'h00); check("R4 cpl carry again", {7'b0, carry}, {7'b0, ref_cy});
    bit_cmd(4'd3, 7'h00); check("R4 clr carry", {7'b0, carry}, {7'b0, ref_cy});
  endtask

  task automatic t_logic();
    // bit 00 is 1, bit 01 is 0
    for (int c = 0; c < 2; c++) begin
      for (int op = 6; op <= 9; op++) begin
        for (int b = 0; b < 2; b++) begin
          bit_cmd(c ? 4'd4 : 4'd3, 7'h00);
          bit_cmd(4'(op), 7'(b));
          check("R5 carry logic", {7'b0, carry}, {7'b0, ref_cy});
        end
      end
    end
  endtask

  task automatic t_move();
    bit_cmd(4'd10, 7'h00); check("R6 load carry from 1", {7'b0, carry}, {7'b0, ref_cy});
    bit_cmd(4'd10, 7'h01); check("R6 load carry from 0", {7'b0, carry}, {7'b0, ref_cy});
    bit_cmd(4'd4, 7'h00);
    bit_cmd(4'd11, 7'h2B); chk_byte("R6 store carry to 25.3", 7'h25);
    bit_cmd(4'd3, 7'h00);
    bit_cmd(4'd11, 7'h00); chk_byte("R6 store carry to 20.0", 7'h20);
  endtask

  task automatic t_testclr();
    wr_byte(7'h25, 8'hFF);
    bit_cmd(4'd4, 7'h00);
    bit_valid = 1'b1; bit_op = 4'd12; bit_addr = 7'h2A; #1;
    check("R7 old bit shown", {7'b0, bit_val}, 8'h01);
    step();
    ref_mem[7'h25][2] = 1'b0;
    check("R7 bit cleared", {7'b0, bit_val}, 8'h00);
    chk_byte("R7 byte after clear", 7'h25);
    check("R7 carry kept", {7'b0, carry}, 8'h01);
  endtask

  task automatic t_collide();
    wr_byte(7'h26, 8'h00);
    byte_we = 1'b1; byte_addr = 7'h26; byte_wdata = 8'h0F;
    bit_valid = 1'b1; bit_op = 4'd1; bit_addr = 7'h37;
    step();
    ref_mem[7'h26] = 8'h0F;
    chk_byte("R8 same byte priority", 7'h26);
    byte_we = 1'b1; byte_addr = 7'h27; byte_wdata = 8'h55;
    bit_valid = 1'b1; bit_op = 4'd1; bit_addr = 7'h40;
    step();
    ref_mem[7'h27] = 8'h55;
    ref_mem[7'h28][0] = 1'b1;
    chk_byte("R8 distinct byte write", 7'h27);
    chk_byte("R8 distinct bit write", 7'h28);
  endtask

  task automatic t_reserved();
    wr_byte(7'h2C, 8'h5A);
    bit_cmd(4'd4, 7'h00);
    for (int op = 13; op < 16; op++) begin
      bit_cmd(4'(op), 7'h61);
      chk_byte("R10 reserved op memory", 7'h2C);
      check("R10 reserved op carry", {7'b0, carry}, 8'h01);
    end
  endtask

  task automatic t_invalid();
    bit_valid = 1'b0; bit_op = 4'd1; bit_addr = 7'h60;
    step();
    chk_byte("R11 invalid set", 7'h2C);
    bit_valid = 1'b0; bit_op = 4'd3;
    step();
    check("R11 invalid carry clr", {7'b0, carry}, 8'h01);
  endtask

  initial begin
    ref_cy = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bytes();
    t_map();
    t_bitops();
    t_carry();
    t_logic();
    t_move();
    t_testclr();
    t_collide();
    t_reserved();
    t_invalid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule